// File: doc/BRIEF.md
# Asynchronous Strobed Bus Master

This block runs single read and write transfers on a 16-bit data bus that addresses memory in 16-bit words. A requester gives a byte address, a size (byte or word), a direction, a 3-bit function code and, for writes, the data. The block drives the word address, an active-low address strobe, an active-low upper and lower data strobe pair and a read/write line. It then waits for an active-low transfer acknowledge from the addressed device before it ends the cycle. Byte-address bit 0 never appears on the bus. The strobe pair selects the byte lane instead: the upper lane holds even bytes and the lower lane holds odd bytes.

Acknowledge arrives asynchronously. A synchronizer samples it, and it is only looked at in the wait phase of the cycle. Each clock that it stays high adds one wait clock. A word access to an odd byte address does not start a bus cycle and produces a one-clock error pulse instead. The next cycle starts only after acknowledge has been seen high again. The requester holds `req` high until either `as_n` falls or `err` pulses.

Top module: `strobed_bus_master`

## Requirements
- R1: After reset, `as_n`, `uds_n`, `lds_n` and `rw` are 1, and `dout_en`, `done` and `err` are 0.
- R2: `bus_addr` (byte address bits 23..1) and `fc_out` are valid at least one clock before `as_n` falls. They hold while `as_n` is low. `rw` is 1 for a read and 0 for a write.
- R3: A word asserts both strobes. A byte at an even address asserts only the upper strobe (`uds_n`=0, `lds_n`=1). A byte at an odd address asserts only the lower strobe (`uds_n`=1, `lds_n`=0).
- R4: A word write drives `wdata` on `dout`. A byte write drives `wdata[7:0]` on both `dout[15:8]` and `dout[7:0]`.
- R5: A word read returns `din` as sampled. A byte read returns the selected lane in `rdata[7:0]` with `rdata[15:8]`=0: `din[15:8]` for an even address and `din[7:0]` for an odd one. `done` is a single-clock pulse with `rdata` valid during it.
- R6: A write follows this order: `as_n` and `rw` fall, then `dout_en` rises, then the data strobes fall, then the strobes rise, then `as_n` rises, then `dout_en` falls, then `rw` rises.
- R7: A read keeps `rw` at 1. It releases the data strobes before `as_n`, and it latches `din` on the clock where acknowledge is seen low.
- R8: Each extra clock that acknowledge stays high lengthens the cycle by exactly one clock. During those clocks `as_n`, the active strobes and `bus_addr` stay put.
- R9: A word request at an odd address gives one `err` pulse and no fall of `as_n`.
- R10: While `dtack_n` is held low, no new cycle starts. Once it is seen high, a pending request proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until `as_n` falls or `err` |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit access, 0 = byte |
| addr | input | 24 | Byte address |
| fc_in | input | 3 | Function code for the transfer |
| wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rdata | output | 16 | Read result, valid with `done` |
| done | output | 1 | One-clock end-of-cycle pulse |
| err | output | 1 | One-clock pulse on a rejected odd word request |
| bus_addr | output | 23 | Word address lines (byte address bits 23..1) |
| fc_out | output | 3 | Function code on the bus |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper-lane (bits 15:8) data strobe, active low |
| lds_n | output | 1 | Lower-lane (bits 7:0) data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |
| dout | output | 16 | Data driven toward the bus |
| dout_en | output | 1 | Output enable for `dout` |
| din | input | 16 | Data from the bus |
| dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
The bench targets four areas.

- **Byte lanes.** It checks even and odd bytes in both directions. A swapped strobe pair or a wrong lane pick would return the neighbouring byte or drive the byte on a lane no device reads.
- **Write ordering.** It timestamps each edge of a write. A design that raises the strobes together with the data enable, or releases data before the address strobe, would give a device a strobe with no data behind it.
- **Wait states.** It compares the same read with zero and with six delay clocks. An acknowledge that is sampled outside the wait phase, or that is ignored, would give a difference other than six.
- **Odd words and held acknowledge.** An odd word request must not produce a strobe. A stuck-low acknowledge must block the next start. A design that fails here would run a misaligned cycle, or finish a fresh cycle at once on a stale acknowledge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ASRT,
    ST_DATA,
    ST_WAIT,
    ST_ACKD,
    ST_RELA,
    ST_TAIL
  } bst_e;
endpackage

// File: rtl/sbm_ack_sync.sv
module sbm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_async,
  output logic ack_n_s
);
  logic [STAGES-1:0] shift_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= ack_n_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= {shift_q[STAGES-2:0], ack_n_async};
      end
    end
  endgenerate

  assign ack_n_s = shift_q[STAGES-1];
endmodule

// File: rtl/sbm_lanes.sv
module sbm_lanes #(
  parameter int DATA_W = 16
) (
  input  logic              word,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic              upper_en,
  output logic              lower_en,
  output logic [DATA_W-1:0] wbus,
  output logic [DATA_W-1:0] rbyte
);
  localparam int LW = DATA_W / 2;

  always_comb begin
    upper_en = word | ~a0;
    lower_en = word | a0;
    wbus     = word ? wdata : {2{wdata[LW-1:0]}};
    if (word)    rbyte = din;
    else if (a0) rbyte = {{LW{1'b0}}, din[LW-1:0]};
    else         rbyte = {{LW{1'b0}}, din[DATA_W-1:LW]};
  end
endmodule

// File: rtl/strobed_bus_master.sv
module strobed_bus_master
  import sbm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int FC_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FC_W-1:0]   fc_in,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-2:0] bus_addr,
  output logic [FC_W-1:0]   fc_out,
  output logic              as_n,
  output logic              uds_n,
  output logic              lds_n,
  output logic              rw,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic [DATA_W-1:0] din,
  input  logic              dtack_n
);
  localparam int WA_W = ADDR_W - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic ack_s;
  sbm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .ack_n_async(dtack_n), .ack_n_s(ack_s)
  );

  bst_e              state_q, state_d;
  logic [WA_W-1:0]   addr_q;
  logic              a0_q, word_q, wr_q;
  logic [FC_W-1:0]   fc_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              err_q;
  logic              take, reject, latch;
  logic              upper_en, lower_en;
  logic [DATA_W-1:0] wbus, rbyte;

  sbm_lanes #(.DATA_W(DATA_W)) u_lanes (
    .word(word_q), .a0(a0_q), .wdata(wdata_q), .din(din),
    .upper_en(upper_en), .lower_en(lower_en), .wbus(wbus), .rbyte(rbyte)
  );

  // next state
  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    reject  = 1'b0;
    latch   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req && ack_s) begin
        if (word && addr[0]) reject = 1'b1;
        else begin
          take    = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: state_d = ST_ASRT;
      ST_ASRT: state_d = wr_q ? ST_DATA : ST_WAIT;
      ST_DATA: state_d = ST_WAIT;
      ST_WAIT: if (!ack_s) begin
        latch   = 1'b1;
        state_d = ST_ACKD;
      end
      ST_ACKD: state_d = ST_RELA;
      ST_RELA: state_d = ST_TAIL;
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= reject;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      addr_q  <= '0;
      a0_q    <= 1'b0;
      word_q  <= 1'b0;
      wr_q    <= 1'b0;
      fc_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (take) begin
        addr_q  <= addr[ADDR_W-1:1];
        a0_q    <= addr[0];
        word_q  <= word;
        wr_q    <= wr;
        fc_q    <= fc_in;
        wdata_q <= wdata;
      end
      if (latch) rdata_q <= rbyte;
    end
  end

  // output decode
  logic as_on, ds_on, wr_span, drv_span;
  always_comb begin
    as_on    = (state_q == ST_ASRT) || (state_q == ST_DATA) ||
               (state_q == ST_WAIT) || (state_q == ST_ACKD);
    ds_on    = (state_q == ST_WAIT) || ((state_q == ST_ASRT) && !wr_q);
    wr_span  = as_on || (state_q == ST_RELA) || (state_q == ST_TAIL);
    drv_span = (state_q == ST_DATA) || (state_q == ST_WAIT) ||
               (state_q == ST_ACKD) || (state_q == ST_RELA);
  end

  assign bus_addr = addr_q;
  assign fc_out   = fc_q;
  assign as_n     = ~as_on;
  assign uds_n    = ~(ds_on & upper_en);
  assign lds_n    = ~(ds_on & lower_en);
  assign rw       = ~(wr_q & wr_span);
  assign dout     = wbus;
  assign dout_en  = wr_q & drv_span;
  assign done     = (state_q == ST_ACKD);
  assign rdata    = rdata_q;
  assign err      = err_q;

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !as_n |-> ($stable(bus_addr) && $stable(fc_out)));
  // R3
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!as_n && !word_q) |-> (uds_n || lds_n));
  // R6
  data_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!rw && (!uds_n || !lds_n)) |-> $past(dout_en));
  // R7
  strobe_before_as_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(as_n) |-> $past(uds_n && lds_n));
  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_WAIT && ack_s) |=> (!as_n && $stable(bus_addr) && $stable(uds_n) && $stable(lds_n)));
  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err |-> (as_n && state_q == ST_IDLE));
  // R10
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_ADDR) |-> $past(ack_s));
endmodule

// File: tb/sim_strobed_bus_master.sv
module sim_strobed_bus_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, wr, word, dtack_n, done, err;
  logic        as_n, uds_n, lds_n, rw, dout_en;
  logic [23:0] addr;
  logic [22:0] bus_addr;
  logic [2:0]  fc_in, fc_out;
  logic [15:0] wdata, rdata, dout, din;

  strobed_bus_master u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word(word), .addr(addr),
    .fc_in(fc_in), .wdata(wdata), .rdata(rdata), .done(done), .err(err),
    .bus_addr(bus_addr), .fc_out(fc_out), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rw(rw), .dout(dout), .dout_en(dout_en), .din(din),
    .dtack_n(dtack_n)
  );

  typedef struct packed {
    logic wr; logic word; logic [23:0] addr; logic [15:0] wdat; logic [15:0] bus;
    logic [3:0] dly; logic [2:0] fc; logic xu; logic xl; logic [15:0] xv; logic xerr;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b0, 1'b1, 24'h000100, 16'h0000, 16'hA55A, 4'd0, 3'd5, 1'b0, 1'b0, 16'hA55A, 1'b0},
    '{1'b0, 1'b0, 24'h000200, 16'h0000, 16'h1234, 4'd2, 3'd1, 1'b0, 1'b1, 16'h0012, 1'b0},
    '{1'b0, 1'b0, 24'h000201, 16'h0000, 16'h1234, 4'd1, 3'd2, 1'b1, 1'b0, 16'h0034, 1'b0},
    '{1'b1, 1'b1, 24'h7FFFFE, 16'hBEEF, 16'h0000, 4'd3, 3'd6, 1'b0, 1'b0, 16'hBEEF, 1'b0},
    '{1'b1, 1'b0, 24'h004000, 16'h00C3, 16'h0000, 4'd0, 3'd1, 1'b0, 1'b1, 16'hC3C3, 1'b0},
    '{1'b1, 1'b0, 24'h005679, 16'h5A77, 16'h0000, 4'd4, 3'd2, 1'b1, 1'b0, 16'h7777, 1'b0},
    '{1'b1, 1'b1, 24'h006543, 16'h1111, 16'h0000, 4'd0, 3'd1, 1'b0, 1'b0, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 24'hFFFFFE, 16'h0000, 16'h0F0F, 4'd7, 3'd5, 1'b0, 1'b0, 16'h0F0F, 1'b0}
  };

  int n_chk = 0, n_bad = 0;
  int cyc = 0, cur_dly = 0, ds_cnt = 0;
  logic [15:0] cur_bus = 16'h0;
  logic ack_force = 1'b0;
  int t_asf, t_asr, t_rwf, t_rwr, t_denr, t_denf, t_dsf, t_dsr, t_done;
  int as_falls = 0, done_cnt = 0, err_cnt = 0, dbl_done = 0;
  logic [22:0] addr_prev_c, addr_at, prev_addr;
  logic [2:0]  fc_prev_c, prev_fc;
  logic        rw_at, cap_u, cap_l;
  logic [15:0] cap_dout, got;
  logic p_as = 1'b1, p_rw = 1'b1, p_den = 1'b0, p_ds = 1'b0, p_done = 1'b0;
  logic ds_act;

  // monitor and peripheral model, all at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    ds_act = !as_n && (!uds_n || !lds_n);
    if (ds_act) ds_cnt = ds_cnt + 1;
    else if (as_n) ds_cnt = 0;
    if (ack_force)                        dtack_n = 1'b0;
    else if (as_n)                        dtack_n = 1'b1;
    else if (ds_act && ds_cnt > cur_dly)  dtack_n = 1'b0;
    din = ds_act ? cur_bus : 16'h0000;
    if (p_as && !as_n) begin
      t_asf = cyc; as_falls = as_falls + 1;
      addr_prev_c = prev_addr; fc_prev_c = prev_fc; addr_at = bus_addr; rw_at = rw;
    end
    if (!p_as && as_n)      t_asr = cyc;
    if (p_rw && !rw)        t_rwf = cyc;
    if (!p_rw && rw)        t_rwr = cyc;
    if (!p_den && dout_en)  t_denr = cyc;
    if (p_den && !dout_en)  t_denf = cyc;
    if (!p_ds && ds_act) begin
      t_dsf = cyc; cap_u = uds_n; cap_l = lds_n; cap_dout = dout;
    end
    if (p_ds && !ds_act)    t_dsr = cyc;
    if (done) begin
      done_cnt = done_cnt + 1; t_done = cyc; got = rdata;
      if (p_done) dbl_done = dbl_done + 1;
    end
    if (err) err_cnt = err_cnt + 1;
    p_as = as_n; p_rw = rw; p_den = dout_en; p_ds = ds_act; p_done = done;
    prev_addr = bus_addr; prev_fc = fc_out;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic clear_stamps();
    t_asf = -1; t_asr = -1; t_rwf = -1; t_rwr = -1; t_denr = -1;
    t_denf = -1; t_dsf = -1; t_dsr = -1; t_done = -1;
  endtask

  task automatic run_vec(input vec_t v, output int len);
    int base_done, base_asf, base_err;
    clear_stamps();
    cur_dly = int'(v.dly); cur_bus = v.bus;
    wr = v.wr; word = v.word; addr = v.addr; wdata = v.wdat; fc_in = v.fc;
    base_done = done_cnt; base_asf = as_falls; base_err = err_cnt;
    req = 1'b1;
    for (int i = 0; i < 50; i++) begin
      tick(1);
      if (!as_n || err_cnt != base_err) break;
    end
    req = 1'b0;
    len = -1;
    if (v.xerr) begin
      tick(10);
      chk(err_cnt - base_err == 1, "R9 err pulses", err_cnt - base_err, 1);
      chk(as_falls == base_asf, "R9 no strobe", as_falls - base_asf, 0);
    end else begin
      for (int i = 0; i < 200; i++) begin
        if (done_cnt != base_done) break;
        tick(1);
      end
      tick(8);
      chk(done_cnt - base_done == 1, "R5 done count", done_cnt - base_done, 1);
      chk(addr_prev_c == v.addr[23:1] && addr_at == v.addr[23:1], "R2 address",
          {9'd0, addr_prev_c}, {9'd0, v.addr[23:1]});
      chk(fc_prev_c == v.fc, "R2 fc", fc_prev_c, v.fc);
      chk(rw_at == !v.wr, "R2 rw", rw_at, !v.wr);
      chk(cap_u == v.xu && cap_l == v.xl, "R3 strobes", {cap_u, cap_l}, {v.xu, v.xl});
      chk(dbl_done == 0, "R5 done one clock", dbl_done, 0);
      if (v.wr) begin
        chk(cap_dout == v.xv, "R4 write lanes", cap_dout, v.xv);
        chk(t_rwf >= 0 && t_rwf < t_denr && t_asf < t_denr && t_denr < t_dsf &&
            t_dsf < t_dsr && t_dsr < t_asr && t_asr < t_denf && t_denf < t_rwr,
            "R6 write order", t_denr, t_dsf);
      end else begin
        chk(got == v.xv, "R5 read data", got, v.xv);
        chk(t_dsr < t_asr && t_rwf == -1, "R7 read release order", t_dsr, t_asr);
      end
      len = t_done - t_asf;
    end
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len0, len6, cnt, base_done;
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; word = 1'b0; addr = '0; wdata = '0;
    fc_in = '0; dtack_n = 1'b1; din = '0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R1
    chk(as_n && uds_n && lds_n && rw && !dout_en && !done && !err, "R1 reset state",
        {as_n, uds_n, lds_n, rw, dout_en, done, err}, 7'b1111000);

    for (int k = 0; k < 8; k++) begin
      int l;
      run_vec(VECS[k], l);
    end

    // R8: same read, zero versus six wait clocks
    run_vec('{1'b0, 1'b1, 24'h000400, 16'h0, 16'h6BD2, 4'd0, 3'd5, 1'b0, 1'b0, 16'h6BD2, 1'b0}, len0);
    run_vec('{1'b0, 1'b1, 24'h000400, 16'h0, 16'h6BD2, 4'd6, 3'd5, 1'b0, 1'b0, 16'h6BD2, 1'b0}, len6);
    chk(len6 - len0 == 6, "R8 wait-state length", len6 - len0, 6);

    // R10: held-low acknowledge blocks a start
    ack_force = 1'b1;
    tick(4);
    cnt = as_falls; base_done = done_cnt;
    cur_dly = 0; cur_bus = 16'h3C3C; wr = 1'b0; word = 1'b1; addr = 24'h000800; fc_in = 3'd1;
    req = 1'b1;
    tick(15);
    chk(as_falls == cnt, "R10 no start under held ack", as_falls - cnt, 0);
    ack_force = 1'b0;
    for (int i = 0; i < 50; i++) begin
      tick(1);
      if (!as_n) break;
    end
    req = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done_cnt != base_done) break;
      tick(1);
    end
    tick(4);
    chk(done_cnt - base_done == 1 && rdata == 16'h3C3C, "R10 proceeds after release", rdata, 16'h3C3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule